// File: doc/BRIEF.md
# Low-Power Wait and Stop Mode Controller

This block sequences the two power-saving modes of a small microcontroller. A **wait** request from the CPU halts the bus clock and the watchdog clock while the oscillator stays on. In this mode the ordinary peripheral clocks are gated only when software has set a peripheral-stop bit beforehand. A write of 1 to the stop-control bit enters **stop**, which turns off the oscillator and every clock derived from it. Either mode ends on an enabled interrupt or on a hardware reset.

The controller also applies three rules at its edges:
- It applies the update rule for the main clock divider bit when stop is entered.
- It keeps the CPU clock-source selection that was in force when the low-power mode was entered.
- It holds the general-purpose port outputs and drives the clock-output pin according to the active mode and the pin's configuration.

All state is held in flops with a synchronous active-high reset. Gate enables follow the registered mode, so they change in the same cycle as the mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: When `wait_req` is high at a clock edge in run mode and the request is accepted, `mode` reads 2'b01 (wait) from the next cycle. `bclk_en` and `wdt_en` are then 0 and `osc_en` is 1. Run mode reads 2'b00.
- R2: In wait mode, `pclk_en` equals the inverse of the peripheral-stop bit. That bit is written at `reg_addr` 2'b01 with `reg_wdata`.
- R3: Every bit of `sub_en` stays 1 in wait mode, whatever the peripheral-stop bit holds.
- R4: A register write of 1 at `reg_addr` 2'b00 in run mode puts `mode` at 2'b10 (stop) and `stop_ctl` at 1 in the next cycle. In stop mode, `bclk_en`, `wdt_en`, `pclk_en`, `sub_en` and `osc_en` are all 0. A stop write takes priority over a simultaneous `wait_req`.
- R5: In wait or stop mode, a cycle with any bit of `irq_req & irq_en` set returns `mode` to 2'b00 in the next cycle. In that same cycle all enables are 1 and `wake` is high for exactly one cycle. An interrupt whose enable bit is 0 leaves the mode unchanged.
- R6: `cpu_src` follows `clk_src_in` with one cycle of latency in run mode. It holds the value captured before entry through the whole low-power period and through the exit cycle.
- R7: The divider bit `div0` is written at `reg_addr` 2'b10. On stop entry it is forced to 1 when `speed` is 2'b00 (high) or 2'b01 (medium). It keeps its value when `speed` is 2'b10 (low) or 2'b11 (low power).
- R8: While `rst` is high, the following hold at the next edge:
  - `mode` is 2'b00.
  - All enables are 1.
  - `stop_ctl`, the peripheral-stop bit, `wake`, `wait_err`, `clkout_pin`, `port_out` and `cpu_src` are 0.
  - `div0` is 1.
  A reset taken during stop clears `stop_ctl`.
- R9: In some cases a `wait_req` is rejected, and the mode stays run. This happens when the request arrives with the peripheral-stop bit at 1 and `speed` at 2'b10 or 2'b11. Instead of entering wait, `wait_err` pulses for one cycle.
- R10: With `clkout_cfg` 2'b00 (subclock), `clkout_pin` copies `clkout_src` with one cycle of latency in run and wait, and is 1 in stop. With any other `clkout_cfg`, it holds its last value in wait and stop.
- R11: `port_out` copies `port_in` with one cycle of latency in run mode. It holds the value latched at entry while in wait or stop.
- R12: Register writes and `wait_req` issued in wait or stop mode have no effect: `stop_ctl`, `div0`, the peripheral-stop bit and `mode` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wait_req | input | 1 | One-cycle wait request strobe from the CPU |
| reg_we | input | 1 | Control register write strobe |
| reg_addr | input | 2 | Register select: 0 stop-control, 1 peripheral-stop, 2 divider bit |
| reg_wdata | input | 1 | Write data bit |
| speed | input | 2 | Speed setting: 0 high, 1 medium, 2 low, 3 low power |
| irq_req | input | NIRQ | Interrupt requests, one per source |
| irq_en | input | NIRQ | Interrupt enable mask |
| clk_src_in | input | SRCW | CPU clock source currently selected |
| clkout_cfg | input | 2 | Clock-output pin configuration, 0 = subclock |
| clkout_src | input | 1 | Current level of the clock routed to the output pin |
| port_in | input | PW | Port output values from the core |
| mode | output | 2 | Current mode: 0 run, 1 wait, 2 stop |
| bclk_en | output | 1 | CPU bus clock enable |
| wdt_en | output | 1 | Watchdog clock enable |
| pclk_en | output | 1 | Gated peripheral clock enable (including ADC clock) |
| sub_en | output | NSUB | Subclock-derived peripheral clock enables |
| osc_en | output | 1 | Oscillator enable |
| clkout_pin | output | 1 | Clock-output pin value |
| port_out | output | PW | Port pin values |
| cpu_src | output | SRCW | CPU clock source in use |
| div0 | output | 1 | Main clock divider select bit |
| stop_ctl | output | 1 | Stop-control bit |
| wake | output | 1 | One-cycle wake pulse to the CPU |
| wait_err | output | 1 | One-cycle rejected-wait flag |

## Verification
Wait is entered with the peripheral-stop bit clear and with it set, which separates the selective peripheral gating from the always-running subclock clocks. Stop is entered once from a fast speed setting and once from a slow one, each time with the divider bit preset to 0, which shows whether the forcing rule looks at the speed. The sequence also includes:
- masked interrupts, writes and wait requests issued during low-power periods;
- a stop write coinciding with a wait request;
- a rejected wait at low speed;
- a reset taken inside stop.

Together these cover the exit conditions and priorities. The clock-output configuration is switched between the subclock setting and another setting across both modes.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10
  } pmode_t;

  localparam logic [1:0] ADDR_STOP  = 2'b00;
  localparam logic [1:0] ADDR_PSTOP = 2'b01;
  localparam logic [1:0] ADDR_DIV   = 2'b10;
  localparam logic [1:0] CKO_SUB    = 2'b00;

  // Low and low-power speed settings share the upper bit.
  function automatic logic is_slow(input logic [1:0] spd);
    return (spd == 2'b10) || (spd == 2'b11);
  endfunction
endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_run,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic       reg_wdata,
  input  logic [1:0] speed,
  output logic       stop_req,
  output logic       stop_q,
  output logic       pstop_q,
  output logic       div0_q
);
  assign stop_req = in_run && reg_we && (reg_addr == ADDR_STOP) && reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q  <= 1'b0;
      pstop_q <= 1'b0;
      div0_q  <= 1'b1;
    end else if (in_run && reg_we) begin
      case (reg_addr)
        ADDR_STOP: begin
          stop_q <= reg_wdata;
          if (reg_wdata && !is_slow(speed)) div0_q <= 1'b1;
        end
        ADDR_PSTOP: pstop_q <= reg_wdata;
        ADDR_DIV:   div0_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  assert_div_forced_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !is_slow(speed)) |=> div0_q);
  assert_div_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_req && is_slow(speed)) |=> (div0_q == $past(div0_q)));
  assert_regs_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    !in_run |=> ($stable(div0_q) && $stable(pstop_q) && $stable(stop_q)));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wait_req,
  input  logic            stop_req,
  input  logic            pstop_q,
  input  logic [1:0]      speed,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output pmode_t          mode_q,
  output pmode_t          mode_d,
  output logic            wake,
  output logic            wait_err
);
  logic pend;
  logic reject;

  assign pend   = |(irq_req & irq_en);
  assign reject = pstop_q && is_slow(speed);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      PM_RUN: begin
        if (stop_req)                mode_d = PM_STOP;
        else if (wait_req && !reject) mode_d = PM_WAIT;
      end
      PM_WAIT, PM_STOP: begin
        if (pend) mode_d = PM_RUN;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PM_RUN;
      wake     <= 1'b0;
      wait_err <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      wake     <= (mode_q != PM_RUN) && pend;
      wait_err <= (mode_q == PM_RUN) && !stop_req && wait_req && reject;
    end
  end

  assert_masked_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ((mode_q != PM_RUN) && ((irq_req & irq_en) == '0)) |=> (mode_q == $past(mode_q)));
  assert_wake_exit_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> ((mode_q == PM_RUN) && ($past(mode_q) != PM_RUN)));
  assert_wake_single_R5: assert property (@(posedge clk) disable iff (rst)
    wake |=> !wake);
  assert_stop_priority_R4: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == PM_RUN) && stop_req) |=> (mode_q == PM_STOP));
  assert_err_stays_run_R9: assert property (@(posedge clk) disable iff (rst)
    wait_err |-> (mode_q == PM_RUN));
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate
  import pwr_pkg::*;
#(
  parameter int NSUB = 3,
  parameter int PW   = 8,
  parameter int SRCW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  pmode_t          mode_q,
  input  pmode_t          mode_d,
  input  logic            pstop_q,
  input  logic [1:0]      clkout_cfg,
  input  logic            clkout_src,
  input  logic [SRCW-1:0] clk_src_in,
  input  logic [PW-1:0]   port_in,
  output logic            bclk_en,
  output logic            wdt_en,
  output logic            pclk_en,
  output logic [NSUB-1:0] sub_en,
  output logic            osc_en,
  output logic            clkout_pin,
  output logic [PW-1:0]   port_out,
  output logic [SRCW-1:0] cpu_src
);
  logic in_run_q;
  logic in_stop_q;

  assign in_run_q  = (mode_q == PM_RUN);
  assign in_stop_q = (mode_q == PM_STOP);

  assign bclk_en = in_run_q;
  assign wdt_en  = in_run_q;
  assign osc_en  = !in_stop_q;
  assign pclk_en = in_run_q || ((mode_q == PM_WAIT) && !pstop_q);

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign sub_en[g] = !in_stop_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clkout_pin <= 1'b0;
      port_out   <= '0;
      cpu_src    <= '0;
    end else begin
      case (mode_d)
        PM_RUN:  clkout_pin <= clkout_src;
        PM_WAIT: if (clkout_cfg == CKO_SUB) clkout_pin <= clkout_src;
        PM_STOP: if (clkout_cfg == CKO_SUB) clkout_pin <= 1'b1;
        default: ;
      endcase
      if (mode_d == PM_RUN) port_out <= port_in;
      if ((mode_d == PM_RUN) && in_run_q) cpu_src <= clk_src_in;
    end
  end

  assert_wait_gates_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_WAIT) |-> (!bclk_en && !wdt_en && osc_en));
  assert_wait_pclk_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_WAIT) |-> (pclk_en == !pstop_q));
  assert_wait_sub_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_WAIT) |-> ($countones(sub_en) == NSUB));
  assert_stop_all_off_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STOP) |-> (!osc_en && !pclk_en && !bclk_en && (sub_en == '0)));
  assert_stop_clkout_R10: assert property (@(posedge clk) disable iff (rst)
    ((mode_d == PM_STOP) && (clkout_cfg == CKO_SUB)) |=> clkout_pin);
  assert_port_hold_R11: assert property (@(posedge clk) disable iff (rst)
    ((mode_q != PM_RUN) && (mode_d != PM_RUN)) |=> $stable(port_out));
  assert_src_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q != PM_RUN) |=> $stable(cpu_src));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int NSUB = 3,
  parameter int PW   = 8,
  parameter int SRCW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wait_req,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wdata,
  input  logic [1:0]      speed,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [SRCW-1:0] clk_src_in,
  input  logic [1:0]      clkout_cfg,
  input  logic            clkout_src,
  input  logic [PW-1:0]   port_in,
  output logic [1:0]      mode,
  output logic            bclk_en,
  output logic            wdt_en,
  output logic            pclk_en,
  output logic [NSUB-1:0] sub_en,
  output logic            osc_en,
  output logic            clkout_pin,
  output logic [PW-1:0]   port_out,
  output logic [SRCW-1:0] cpu_src,
  output logic            div0,
  output logic            stop_ctl,
  output logic            wake,
  output logic            wait_err
);
  pmode_t mode_q;
  pmode_t mode_d;
  logic   stop_req;
  logic   pstop_q;

  pwr_cfg_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .in_run    (mode_q == PM_RUN),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .speed     (speed),
    .stop_req  (stop_req),
    .stop_q    (stop_ctl),
    .pstop_q   (pstop_q),
    .div0_q    (div0)
  );

  pwr_seq #(.NIRQ(NIRQ)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wait_req (wait_req),
    .stop_req (stop_req),
    .pstop_q  (pstop_q),
    .speed    (speed),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .mode_q   (mode_q),
    .mode_d   (mode_d),
    .wake     (wake),
    .wait_err (wait_err)
  );

  pwr_gate #(.NSUB(NSUB), .PW(PW), .SRCW(SRCW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .pstop_q    (pstop_q),
    .clkout_cfg (clkout_cfg),
    .clkout_src (clkout_src),
    .clk_src_in (clk_src_in),
    .port_in    (port_in),
    .bclk_en    (bclk_en),
    .wdt_en     (wdt_en),
    .pclk_en    (pclk_en),
    .sub_en     (sub_en),
    .osc_en     (osc_en),
    .clkout_pin (clkout_pin),
    .port_out   (port_out),
    .cpu_src    (cpu_src)
  );

  assign mode = mode_q;

  assert_reset_clears_stop_R8: assert property (@(posedge clk)
    $past(rst) |-> (!stop_ctl && div0 && (mode == 2'b00)));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 8;
  localparam int NSUB = 3;
  localparam int PW   = 8;
  localparam int SRCW = 2;
  localparam int WDOG = 20000;

  logic clk = 0;
  logic rst = 1;
  logic wait_req = 0, reg_we = 0, reg_wdata = 0, clkout_src = 0;
  logic [1:0] reg_addr = 0, speed = 0, clkout_cfg = 0;
  logic [NIRQ-1:0] irq_req = 0, irq_en = 0;
  logic [SRCW-1:0] clk_src_in = 0;
  logic [PW-1:0] port_in = 0;
  logic [1:0] mode;
  logic bclk_en, wdt_en, pclk_en, osc_en, clkout_pin, div0, stop_ctl, wake, wait_err;
  logic [NSUB-1:0] sub_en;
  logic [PW-1:0] port_out;
  logic [SRCW-1:0] cpu_src;

  pwr_mode_ctrl #(.NIRQ(NIRQ), .NSUB(NSUB), .PW(PW), .SRCW(SRCW)) u_dut (
    .clk(clk), .rst(rst), .wait_req(wait_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .speed(speed), .irq_req(irq_req), .irq_en(irq_en),
    .clk_src_in(clk_src_in), .clkout_cfg(clkout_cfg), .clkout_src(clkout_src),
    .port_in(port_in), .mode(mode), .bclk_en(bclk_en), .wdt_en(wdt_en),
    .pclk_en(pclk_en), .sub_en(sub_en), .osc_en(osc_en), .clkout_pin(clkout_pin),
    .port_out(port_out), .cpu_src(cpu_src), .div0(div0), .stop_ctl(stop_ctl),
    .wake(wake), .wait_err(wait_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) clkout_src <= ~clkout_src;

  int checks = 0, errors = 0, cyc = 0;
  bit started = 0, done = 0;

  // Behavioural reference state: 0 run, 1 wait, 2 stop
  int m_mode, m_pstop, m_div, m_stop, m_src, m_port, m_ck, m_wake, m_err;

  always @(posedge clk) begin
    int nm, oldp;
    if (rst) begin
      m_mode = 0; m_pstop = 0; m_div = 1; m_stop = 0; m_src = 0;
      m_port = 0; m_ck = 0; m_wake = 0; m_err = 0;
      started = 1;
    end else begin
      nm = m_mode; oldp = m_pstop; m_wake = 0; m_err = 0;
      if (m_mode == 0) begin
        if (reg_we) begin
          if (reg_addr == 0) begin
            m_stop = reg_wdata;
            if (reg_wdata) begin
              nm = 2;
              if (speed < 2) m_div = 1;
            end
          end else if (reg_addr == 1) m_pstop = reg_wdata;
          else if (reg_addr == 2) m_div = reg_wdata;
        end
        if (nm == 0 && wait_req) begin
          if (oldp == 1 && speed >= 2) m_err = 1;
          else nm = 1;
        end
      end else if ((irq_req & irq_en) != 0) begin
        nm = 0; m_wake = 1;
      end
      if (nm == 0) m_ck = clkout_src;
      else if (clkout_cfg == 0) m_ck = (nm == 1) ? int'(clkout_src) : 1;
      if (nm == 0) m_port = port_in;
      if (nm == 0 && m_mode == 0) m_src = clk_src_in;
      m_mode = nm;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (started && !done) begin
      chk("R1/R4/R5 mode", int'(mode), m_mode);
      chk("R1 bclk_en", int'(bclk_en), m_mode == 0);
      chk("R1 wdt_en", int'(wdt_en), m_mode == 0);
      chk("R2 pclk_en", int'(pclk_en), (m_mode == 0) || (m_mode == 1 && m_pstop == 0));
      chk("R3 sub_en", int'(sub_en), (m_mode == 2) ? 0 : (1 << NSUB) - 1);
      chk("R4 osc_en", int'(osc_en), m_mode != 2);
      chk("R4/R8 stop_ctl", int'(stop_ctl), m_stop);
      chk("R5 wake", int'(wake), m_wake);
      chk("R6 cpu_src", int'(cpu_src), m_src);
      chk("R7 div0", int'(div0), m_div);
      chk("R9 wait_err", int'(wait_err), m_err);
      chk("R10 clkout_pin", int'(clkout_pin), m_ck);
      chk("R11 port_out", int'(port_out), m_port);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic pulse_wait();
    wait_req = 1; step(1); wait_req = 0;
  endtask

  task automatic fire_irq(int bitn);
    irq_req = '0; irq_req[bitn] = 1; irq_en[bitn] = 1;
    step(1);
    irq_req = '0; irq_en = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    step(3);                       // R8 reset state
    rst = 0;
    port_in = 8'h5A; clk_src_in = 2'd1; step(3);
    // R1 R2 R3 R6 R11 R5: wait with peripheral-stop clear, masked irq then enabled irq
    pulse_wait();
    port_in = 8'hC3; clk_src_in = 2'd3; step(2);
    irq_req = 8'h10; irq_en = 8'h00; step(3); irq_req = 0;   // R5 masked
    wr(2'b00, 1'b1);               // R12 ignored in wait
    pulse_wait();
    fire_irq(2); step(3);
    // R2: wait with peripheral-stop set
    wr(2'b01, 1'b1); pulse_wait(); step(3); fire_irq(0); step(2);
    // R9: rejected at low speed
    speed = 2'b10; pulse_wait(); step(2);
    speed = 2'b11; pulse_wait(); step(2);
    // R7: stop from slow speed keeps div0 at 0
    wr(2'b01, 1'b0); wr(2'b10, 1'b0); step(1);
    wr(2'b00, 1'b1); step(3);
    wr(2'b10, 1'b1); wr(2'b01, 1'b1); pulse_wait(); step(2);  // R12
    fire_irq(7); step(2);
    // R7: stop from medium speed forces div0
    speed = 2'b01; wr(2'b10, 1'b0); wr(2'b00, 1'b1); step(3); fire_irq(5); step(2);
    // R10: other clock-output setting in wait and stop
    clkout_cfg = 2'b01; speed = 2'b00; wr(2'b01, 1'b0);
    pulse_wait(); step(3); fire_irq(1); step(2);
    wr(2'b00, 1'b1); step(3); fire_irq(3); step(2);
    clkout_cfg = 2'b00;
    // R4: stop write and wait request together
    wait_req = 1; reg_we = 1; reg_addr = 2'b00; reg_wdata = 1; step(1);
    wait_req = 0; reg_we = 0; reg_wdata = 0; step(3);
    // R8: reset during stop clears stop_ctl
    rst = 1; step(2); rst = 0; step(3);
    finish_run();
  end

  initial begin
    #(WDOG * CLK_PERIOD);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule